// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the combinational integer execute stage of a classic 32-bit load/store RISC pipeline. Each cycle it takes the raw 32-bit instruction word and the two operand values already read from the register file. It decodes the primary opcode and, for register-format words, the 6-bit function field. It then computes the integer result in the same cycle. Nothing inside the block is stored.

The operation comes straight from the architectural encodings, not from a separate ALU-control code. The opcode also picks the kind of immediate extension. Along with the result, the block raises a signed-overflow flag for the trapping add/subtract forms and an illegal flag for any word it does not implement. The surrounding pipeline uses these flags to raise exceptions.

Top module: `rxe_exec_unit`

## Requirements
- R1: A register-format word has opcode bits [31:26] equal to 0 and selects its operation with function bits [5:0]. Function 0x20 (add) and 0x21 (unsigned add) return src_a + src_b modulo 2^32.
- R2: Function 0x22 (subtract) and 0x23 (unsigned subtract) return src_a - src_b modulo 2^32.
- R3: ovf_o is 1 exactly when function 0x20, function 0x22 or opcode 0x08 produces a result outside the signed 32-bit range. Function 0x21, function 0x23, opcode 0x09 and every other operation hold ovf_o at 0.
- R4: Function 0x24 returns the bitwise AND of the operands, 0x25 the OR, 0x26 the XOR and 0x27 the NOR.
- R5: Function 0x2A returns 1 when src_a < src_b as signed numbers, and 0x2B returns 1 when the comparison holds as unsigned numbers. Otherwise both return 0, and bits [31:1] are always 0.
- R6: Functions 0x00, 0x02 and 0x03 shift src_b by the amount in bits [10:6] (0 to 31), left with zero fill, right with zero fill, and right with sign fill respectively. src_a has no effect on them.
- R7: Immediate opcodes 0x08 (add) and 0x09 (unsigned add) return src_a plus the sign-extended 16-bit immediate in bits [15:0].
- R8: Opcodes 0x0A and 0x0B compare src_a with the sign-extended immediate, as signed and as unsigned numbers respectively, and return 1 or 0.
- R9: Opcodes 0x0C and 0x0D return the AND and the OR of src_a with the zero-extended immediate.
- R10: Opcode 0x0F returns the immediate in bits [31:16] with zeros in bits [15:0]. Neither operand has an effect on it.
- R11: Any opcode other than 0x00, 0x08 to 0x0D and 0x0F, and any function code under opcode 0 other than those listed in R1, R2 and R4 to R6, sets illegal_o to 1, result_o to 0 and ovf_o to 0. Every listed encoding holds illegal_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode and execute |
| src_a_i | input | 32 | First operand (register selected by bits [25:21]) |
| src_b_i | input | 32 | Second operand (register selected by bits [20:16]); the value shifted by shift operations |
| result_o | output | 32 | Computed result |
| ovf_o | output | 1 | Signed overflow of a trapping add or subtract |
| illegal_o | output | 1 | Instruction word not implemented by this unit |

## Verification
The embedded checks hold whenever the inputs are known. They cover these invariants: an illegal word drives a zero result with no overflow, overflow never appears outside the trapping add/subtract forms, comparisons return only 0 or 1, load-upper leaves the low half clear, and a shift by zero passes src_b through unchanged. Those invariants cannot show that the arithmetic, the immediate extension or each code-to-operation mapping is right. The bench shows that. It sweeps all 64 opcodes and all 64 function codes over corner-value operand pairs and every shift distance, and compares each result with a reference model that uses wide signed arithmetic.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;
  localparam int IMM_W   = 16;
  localparam int SHAMT_W = 5;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  // function field codes under OPC_REG
  localparam logic [FUNCT_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNCT_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FUNCT_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FUNCT_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FUNCT_W-1:0] FN_AND  = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FUNCT_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FUNCT_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FUNCT_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI, ALU_NONE
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG, OPB_SEXT, OPB_ZEXT
  } opb_sel_e;

  typedef struct packed {
    alu_op_e  op;
    opb_sel_e opb;
    logic     ovf_en;
    logic     bad;
  } dec_t;

endpackage

// File: rtl/rxe_decode.sv
module rxe_decode
  import rxe_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output dec_t               dec_o
);

  function automatic dec_t mk(alu_op_e op, opb_sel_e opb, logic ovf_en);
    dec_t d;
    d.op     = op;
    d.opb    = opb;
    d.ovf_en = ovf_en;
    d.bad    = (op == ALU_NONE);
    return d;
  endfunction

  dec_t reg_dec;
  dec_t imm_dec;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  reg_dec = mk(ALU_ADD,  OPB_REG, 1'b1);
      FN_ADDU: reg_dec = mk(ALU_ADD,  OPB_REG, 1'b0);
      FN_SUB:  reg_dec = mk(ALU_SUB,  OPB_REG, 1'b1);
      FN_SUBU: reg_dec = mk(ALU_SUB,  OPB_REG, 1'b0);
      FN_AND:  reg_dec = mk(ALU_AND,  OPB_REG, 1'b0);
      FN_OR:   reg_dec = mk(ALU_OR,   OPB_REG, 1'b0);
      FN_XOR:  reg_dec = mk(ALU_XOR,  OPB_REG, 1'b0);
      FN_NOR:  reg_dec = mk(ALU_NOR,  OPB_REG, 1'b0);
      FN_SLT:  reg_dec = mk(ALU_SLT,  OPB_REG, 1'b0);
      FN_SLTU: reg_dec = mk(ALU_SLTU, OPB_REG, 1'b0);
      FN_SLL:  reg_dec = mk(ALU_SLL,  OPB_REG, 1'b0);
      FN_SRL:  reg_dec = mk(ALU_SRL,  OPB_REG, 1'b0);
      FN_SRA:  reg_dec = mk(ALU_SRA,  OPB_REG, 1'b0);
      default: reg_dec = mk(ALU_NONE, OPB_REG, 1'b0);
    endcase
  end

  always_comb begin
    unique case (opcode_i)
      OPC_ADDI:  imm_dec = mk(ALU_ADD,  OPB_SEXT, 1'b1);
      OPC_ADDIU: imm_dec = mk(ALU_ADD,  OPB_SEXT, 1'b0);
      OPC_SLTI:  imm_dec = mk(ALU_SLT,  OPB_SEXT, 1'b0);
      OPC_SLTIU: imm_dec = mk(ALU_SLTU, OPB_SEXT, 1'b0);
      OPC_ANDI:  imm_dec = mk(ALU_AND,  OPB_ZEXT, 1'b0);
      OPC_ORI:   imm_dec = mk(ALU_OR,   OPB_ZEXT, 1'b0);
      OPC_LUI:   imm_dec = mk(ALU_LUI,  OPB_ZEXT, 1'b0);
      default:   imm_dec = mk(ALU_NONE, OPB_REG,  1'b0);
    endcase
  end

  assign dec_o = (opcode_i == OPC_REG) ? reg_dec : imm_dec;

  // R3: only add and subtract may ever enable the overflow flag
  always_comb begin
    if (!$isunknown({opcode_i, funct_i}))
      a_r3_ovf_only_addsub: assert (!dec_o.ovf_en || dec_o.op == ALU_ADD || dec_o.op == ALU_SUB)
        else $error("ovf enabled for non add/sub op");
  end

  // R11: an illegal decode never carries an immediate or overflow enable
  always_comb begin
    if (!$isunknown({opcode_i, funct_i}))
      a_r11_bad_clean: assert (!dec_o.bad || (!dec_o.ovf_en && dec_o.opb == OPB_REG))
        else $error("illegal decode carries side controls");
  end

endmodule

// File: rtl/rxe_arith.sv
module rxe_arith
  import rxe_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  input  logic            ovf_en_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);

  localparam int MSB = XLEN - 1;

  // one shared adder: subtract is a + ~b + 1
  function automatic logic [XLEN:0] add_carry(logic [XLEN-1:0] x, logic [XLEN-1:0] y, logic cin);
    return {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(logic xs, logic ys, logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic            is_sub;
  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   sum_c;
  logic [XLEN-1:0] sum;
  logic            carry_out;
  logic            raw_ovf;
  logic            lt_signed;
  logic            lt_unsigned;

  assign is_sub      = (op_i != ALU_ADD);
  assign b_eff       = is_sub ? ~b_i : b_i;
  assign sum_c       = add_carry(a_i, b_eff, is_sub);
  assign sum         = sum_c[XLEN-1:0];
  assign carry_out   = sum_c[XLEN];
  assign raw_ovf     = signed_ovf(a_i[MSB], b_eff[MSB], sum[MSB]);
  assign lt_signed   = sum[MSB] ^ raw_ovf;
  assign lt_unsigned = ~carry_out;

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    unique case (op_i)
      ALU_ADD, ALU_SUB: begin
        res_o = sum;
        ovf_o = ovf_en_i & raw_ovf;
      end
      ALU_SLT:  res_o = {{(XLEN-1){1'b0}}, lt_signed};
      ALU_SLTU: res_o = {{(XLEN-1){1'b0}}, lt_unsigned};
      default: ;
    endcase
  end

  // R5: a comparison result is a single bit
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i}) && (op_i == ALU_SLT || op_i == ALU_SLTU))
      a_r5_slt_boolean: assert (res_o[XLEN-1:1] == '0)
        else $error("comparison result wider than one bit");
  end

  // R3: overflow only when the decode enabled it
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i, ovf_en_i}))
      a_r3_no_overflow: assert (!ovf_o || ovf_en_i)
        else $error("overflow raised by non-trapping op");
  end

endmodule

// File: rtl/rxe_logic_shift.sv
module rxe_logic_shift
  import rxe_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SHW   = 5,
  parameter int HALFW = 16
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SHW-1:0]  shamt_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o
);

  function automatic logic [XLEN-1:0] shift_right(logic [XLEN-1:0] v, logic [SHW-1:0] n, logic fill);
    logic [2*XLEN-1:0] wide;
    wide = {{XLEN{fill}}, v} >> n;
    return wide[XLEN-1:0];
  endfunction

  always_comb begin
    res_o = '0;
    unique case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      ALU_NOR: res_o = ~(a_i | b_i);
      ALU_SLL: res_o = b_i << shamt_i;
      ALU_SRL: res_o = shift_right(b_i, shamt_i, 1'b0);
      ALU_SRA: res_o = shift_right(b_i, shamt_i, b_i[XLEN-1]);
      ALU_LUI: res_o = b_i << HALFW;
      default: ;
    endcase
  end

  // R6: shifting by zero passes the shifted operand through
  always_comb begin
    if (!$isunknown({b_i, shamt_i, op_i}) && shamt_i == '0 &&
        (op_i == ALU_SLL || op_i == ALU_SRL || op_i == ALU_SRA))
      a_r6_shift_zero_identity: assert (res_o == b_i)
        else $error("zero shift altered operand");
  end

endmodule

// File: rtl/rxe_exec_unit.sv
module rxe_exec_unit
  import rxe_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] result_o,
  output logic            ovf_o,
  output logic            illegal_o
);

  localparam int SHW = $clog2(XLEN);

  dec_t             dec;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_sext;
  logic [XLEN-1:0]  imm_zext;
  logic [XLEN-1:0]  opnd_b;
  logic [SHW-1:0]   shamt;
  logic [XLEN-1:0]  arith_res;
  logic             arith_ovf;
  logic [XLEN-1:0]  ls_res;
  logic             is_arith;
  logic             unused_reg_fields;

  assign imm      = instr_i[IMM_W-1:0];
  assign imm_sext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_zext = {{(XLEN-IMM_W){1'b0}}, imm};
  assign shamt    = instr_i[6 +: SHW];
  assign unused_reg_fields = ^instr_i[25:16];

  rxe_decode u_decode (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[FUNCT_W-1:0]),
    .dec_o    (dec)
  );

  always_comb begin
    unique case (dec.opb)
      OPB_SEXT: opnd_b = imm_sext;
      OPB_ZEXT: opnd_b = imm_zext;
      default:  opnd_b = src_b_i;
    endcase
  end

  rxe_arith #(.XLEN(XLEN)) u_arith (
    .a_i      (src_a_i),
    .b_i      (opnd_b),
    .op_i     (dec.op),
    .ovf_en_i (dec.ovf_en),
    .res_o    (arith_res),
    .ovf_o    (arith_ovf)
  );

  rxe_logic_shift #(.XLEN(XLEN), .SHW(SHW), .HALFW(IMM_W)) u_logic (
    .a_i     (src_a_i),
    .b_i     (opnd_b),
    .shamt_i (shamt),
    .op_i    (dec.op),
    .res_o   (ls_res)
  );

  assign is_arith = (dec.op == ALU_ADD) || (dec.op == ALU_SUB) ||
                    (dec.op == ALU_SLT) || (dec.op == ALU_SLTU);

  always_comb begin
    if (dec.bad) begin
      result_o = '0;
      ovf_o    = 1'b0;
    end else if (is_arith) begin
      result_o = arith_res;
      ovf_o    = arith_ovf;
    end else begin
      result_o = ls_res;
      ovf_o    = 1'b0;
    end
  end

  assign illegal_o = dec.bad;

  // R11: an illegal word is quiet at the outputs
  always_comb begin
    if (!$isunknown({instr_i, src_a_i, src_b_i}) && illegal_o)
      a_r11_illegal_quiet: assert (result_o == '0 && !ovf_o)
        else $error("illegal word produced output");
  end

  // R10: load-upper leaves the low half clear and holds the immediate above it
  always_comb begin
    if (!$isunknown(instr_i) && instr_i[31:26] == OPC_LUI)
      a_r10_lui_shape: assert (result_o[IMM_W-1:0] == '0 && result_o[XLEN-1 -: IMM_W] == imm)
        else $error("load-upper result malformed");
  end

endmodule

// File: tb/rxe_exec_unit_tb_top.sv
module rxe_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic [31:0] instr;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] result;
  logic        ovf;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rxe_exec_unit dut_i (
    .instr_i   (instr),
    .src_a_i   (src_a),
    .src_b_i   (src_b),
    .result_o  (result),
    .ovf_o     (ovf),
    .illegal_o (illegal)
  );

  logic [31:0] corners [8];
  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000; corners[5] = 32'h0000_7FFF;
    corners[6] = 32'hFFFF_8000; corners[7] = 32'h5A5A_C3C3;
  end

  // reference model: wide signed arithmetic, written independently
  function automatic void model(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] r, output logic v, output logic bad,
                                output string tag);
    logic [5:0]  opc = iw[31:26];
    logic [5:0]  fn  = iw[5:0];
    int unsigned sh  = iw[10:6];
    longint      sa  = longint'($signed(a));
    longint      sb  = longint'($signed(b));
    longint      si  = longint'($signed(iw[15:0]));
    longint      w;
    logic [31:0] ui  = 32'(si);
    r = 32'h0; v = 1'b0; bad = 1'b0; tag = "R11";
    if (opc == 6'h00) begin
      case (fn)
        6'h20, 6'h21: begin
          w = sa + sb; r = 32'(w); tag = "R1/R3";
          v = (fn == 6'h20) && (w > 64'sd2147483647 || w < -64'sd2147483648);
        end
        6'h22, 6'h23: begin
          w = sa - sb; r = 32'(w); tag = "R2/R3";
          v = (fn == 6'h22) && (w > 64'sd2147483647 || w < -64'sd2147483648);
        end
        6'h24: begin r = a & b;    tag = "R4"; end
        6'h25: begin r = a | b;    tag = "R4"; end
        6'h26: begin r = a ^ b;    tag = "R4"; end
        6'h27: begin r = ~(a | b); tag = "R4"; end
        6'h2A: begin r = (sa < sb) ? 32'd1 : 32'd0; tag = "R5"; end
        6'h2B: begin r = (a < b)   ? 32'd1 : 32'd0; tag = "R5"; end
        6'h00: begin r = b << sh; tag = "R6"; end
        6'h02: begin r = b >> sh; tag = "R6"; end
        6'h03: begin r = 32'(sb >>> sh); tag = "R6"; end
        default: bad = 1'b1;
      endcase
    end else begin
      case (opc)
        6'h08, 6'h09: begin
          w = sa + si; r = 32'(w); tag = "R7/R3";
          v = (opc == 6'h08) && (w > 64'sd2147483647 || w < -64'sd2147483648);
        end
        6'h0A: begin r = (sa < si) ? 32'd1 : 32'd0; tag = "R8"; end
        6'h0B: begin r = (a < ui)  ? 32'd1 : 32'd0; tag = "R8"; end
        6'h0C: begin r = a & {16'h0, iw[15:0]}; tag = "R9"; end
        6'h0D: begin r = a | {16'h0, iw[15:0]}; tag = "R9"; end
        6'h0F: begin r = iw[15:0] * 32'h1_0000; tag = "R10"; end
        default: bad = 1'b1;
      endcase
    end
  endfunction

  task automatic apply(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic        ev, eb;
    string       tag;
    @(posedge clk);
    instr = iw; src_a = a; src_b = b;
    @(negedge clk);
    model(iw, a, b, er, ev, eb, tag);
    checks++;
    if (result !== er || ovf !== ev || illegal !== eb) begin
      errors++;
      $display("FAIL %s instr=%h a=%h b=%h: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
               tag, iw, a, b, result, ovf, illegal, er, ev, eb);
    end
  endtask

  logic [31:0] lfsr = 32'hACE1_2468;
  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    instr = '0; src_a = '0; src_b = '0;
    // reset-state style check: all-zero word is a left shift of zero by zero (R6)
    apply(32'h0, 32'h0, 32'h0);

    // R1 R2 R4 R5 R11: every function code under opcode 0 on corner operand pairs
    for (int fn = 0; fn < 64; fn++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          lfsr = next_rand(lfsr);
          apply({6'h00, lfsr[25:11], 5'd0, 6'(fn)}, corners[i], corners[j]);
        end

    // R6: every shift distance, src_a varied to show it has no effect
    for (int fn = 0; fn < 4; fn++)
      for (int sh = 0; sh < 32; sh++)
        for (int j = 0; j < 8; j++) begin
          lfsr = next_rand(lfsr);
          apply({6'h00, lfsr[14:0], 5'(sh), 6'(fn)}, lfsr, corners[j]);
        end

    // R7 R8 R9 R10 R11: every opcode, corner operands and corner immediates
    for (int op = 1; op < 64; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          lfsr = next_rand(lfsr);
          apply({6'(op), lfsr[9:0], corners[j][15:0]}, corners[i], lfsr);
        end

    // R3 boundary: exact overflow edges for add, sub and add-immediate
    apply({6'h00, 15'h0, 5'd0, 6'h20}, 32'h7FFF_FFFF, 32'h0000_0001);
    apply({6'h00, 15'h0, 5'd0, 6'h21}, 32'h7FFF_FFFF, 32'h0000_0001);
    apply({6'h00, 15'h0, 5'd0, 6'h22}, 32'h8000_0000, 32'h0000_0001);
    apply({6'h00, 15'h0, 5'd0, 6'h23}, 32'h8000_0000, 32'h0000_0001);
    apply({6'h08, 10'h0, 16'hFFFF}, 32'h8000_0000, 32'h0);
    apply({6'h09, 10'h0, 16'hFFFF}, 32'h8000_0000, 32'h0);

    // random sweep over all words and operands
    for (int k = 0; k < 6000; k++) begin
      logic [31:0] iw, a;
      lfsr = next_rand(lfsr); iw = lfsr;
      lfsr = next_rand(lfsr); a  = lfsr;
      lfsr = next_rand(lfsr);
      apply(iw, a, lfsr);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule